// File: doc/BRIEF.md
# Serial Port Modem Status Generator

This block produces the modem status byte of a 16550-style serial port from the modem control byte that software writes. A small register bus reaches two byte registers. Select 0 is the control register and select 1 is the status register. The status byte has two halves. The upper nibble holds four live line bits: clear-to-send, data-set-ready, ring indicate and carrier detect. The lower nibble holds four sticky change flags.

There are no real modem pins. When loopback is selected in the control byte, the live bits are taken from the control outputs. When loopback is off, carrier detect and data-set-ready are held high, so that software waiting on them never blocks. A change flag is set only as a result of a control write. A status read returns the byte and clears the change flags. A single output reports that at least one change flag is set, for use by interrupt logic.

A two-state machine tracks the live-bit source. Its states are LIVE_FIXED and LIVE_LOOP. The transition ENTER_LOOP fires on a control write with bit 4 set while in LIVE_FIXED. The transition LEAVE_LOOP fires on a control write with bit 4 clear while in LIVE_LOOP. Every other cycle takes the transition HOLD and keeps the state. The state that is current after each edge selects how the written control byte is mapped into the live nibble.

Top module: `modem_status_gen`

## Requirements
- R1: With control bit 4 (loopback) set, the status bits follow the control bits as follows. Status bit 4 (CTS) equals control bit 1 (RTS). Status bit 5 (DSR) equals control bit 0 (DTR). Status bit 6 (RI) equals control bit 2 (OUT1). Status bit 7 (DCD) equals control bit 3 (OUT2).
- R2: With control bit 4 clear, status bits 7:4 read 4'b1010: DCD and DSR high, RI and CTS low.
- R3: A control write (bus_sel=0) stores bits 4:0 of the written byte and forces bits 7:5 to zero. The stored value appears on ctrl_out and on rdata when bus_sel=0.
- R4: A control write sets the following change flags when the matching live bit differs from its previous value: status bit 0 for CTS, bit 1 for DSR and bit 3 for DCD.
- R5: Status bit 2 (ring change) is set only when RI goes from 1 to 0 on a control write. A rising RI leaves it unchanged.
- R6: Change flags that are already set stay set across control writes. Each control write replaces status bits 7:4 with the newly computed live bits.
- R7: A status read (bus_rd=1, bus_wr=0, bus_sel=1) shows the current status on rdata in that cycle. Status bits 3:0 are zero from the next cycle on. A read of the control register has no side effect.
- R8: A write with bus_sel=1 changes neither the status register nor the control register.
- R9: After reset the control register holds CTRL_RESET masked to bits 4:0. The status register holds the live bits of that value with all change flags zero. With the default CTRL_RESET of 0 this gives 8'hA0.
- R10: delta_any is 1 exactly when any of status bits 3:0 is set.
- R11: When bus_wr and bus_rd are both high, only the write acts. The clearing effect of the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Selected register value (combinational) |
| ctrl_out | output | 8 | Stored control byte |
| delta_any | output | 1 | At least one change flag is set |

## Verification
The bench aims at four weak spots. The first is ring-indicate edges in both directions: a design that flags the rising edge would set bit 2 when OUT1 is raised in loopback. The second is leaving loopback while flags are pending: a design that overwrites the lower nibble would lose the flags that were already set. The third is status writes and simultaneous read and write strobes: a design that lets them through would corrupt the byte or clear flags it should not. The fourth is a long random mix of operations, checked against a behavioural model on every clock, which would expose a mapping that swaps any pair of live bits.

// File: rtl/mst_pkg.sv
package mst_pkg;
    // control byte fields
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    localparam int C_LOOP = 4;
    localparam logic [7:0] CTRL_KEEP = 8'h1F;

    // live nibble positions (status bit minus 4)
    localparam int L_CTS = 0;
    localparam int L_DSR = 1;
    localparam int L_RI  = 2;
    localparam int L_DCD = 3;
    localparam int LIVE_W = 4;

    typedef enum logic {
        LIVE_FIXED = 1'b0,
        LIVE_LOOP  = 1'b1
    } mst_mode_e;

    function automatic logic [LIVE_W-1:0] live_of(input logic [7:0] c);
        logic [LIVE_W-1:0] v;
        if (c[C_LOOP]) begin
            v[L_CTS] = c[C_RTS];
            v[L_DSR] = c[C_DTR];
            v[L_RI]  = c[C_OUT1];
            v[L_DCD] = c[C_OUT2];
        end else begin
            v = '0;
            v[L_DSR] = 1'b1;
            v[L_DCD] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/mst_live_map.sv
module mst_live_map
    import mst_pkg::*;
(
    input  logic [7:0]        ctrl,
    output logic [LIVE_W-1:0] loop_live,
    output logic [LIVE_W-1:0] fixed_live
);
    always_comb begin
        loop_live        = '0;
        loop_live[L_CTS] = ctrl[C_RTS];
        loop_live[L_DSR] = ctrl[C_DTR];
        loop_live[L_RI]  = ctrl[C_OUT1];
        loop_live[L_DCD] = ctrl[C_OUT2];
    end

    always_comb begin
        fixed_live        = '0;
        fixed_live[L_DSR] = 1'b1;
        fixed_live[L_DCD] = 1'b1;
    end
endmodule

// File: rtl/mst_delta_gen.sv
module mst_delta_gen
    import mst_pkg::*;
(
    input  logic [LIVE_W-1:0] old_live,
    input  logic [LIVE_W-1:0] new_live,
    output logic [LIVE_W-1:0] evt
);
    // level change on CTS, DSR, DCD; trailing edge only on RI
    for (genvar i = 0; i < LIVE_W; i++) begin : g_bit
        if (i == L_RI) begin : g_trail
            assign evt[i] = old_live[i] & ~new_live[i];
        end else begin : g_any
            assign evt[i] = old_live[i] ^ new_live[i];
        end
    end
endmodule

// File: rtl/mst_mode_fsm.sv
module mst_mode_fsm
    import mst_pkg::*;
#(
    parameter mst_mode_e RESET_MODE = LIVE_FIXED
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  logic      loop_req,
    output mst_mode_e mode_q,
    output logic      next_is_loop
);
    mst_mode_e mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= RESET_MODE;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            LIVE_FIXED: if (ctrl_wr && loop_req)  mode_d = LIVE_LOOP;   // ENTER_LOOP
            LIVE_LOOP:  if (ctrl_wr && !loop_req) mode_d = LIVE_FIXED;  // LEAVE_LOOP
            default:    mode_d = LIVE_FIXED;
        endcase
        next_is_loop = (mode_d == LIVE_LOOP);
    end
endmodule

// File: rtl/modem_status_gen.sv
module modem_status_gen
    import mst_pkg::*;
#(
    parameter logic [7:0] CTRL_RESET = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] rdata,
    output logic [7:0] ctrl_out,
    output logic       delta_any
);
    localparam logic [7:0]        CTRL_INIT  = CTRL_RESET & CTRL_KEEP;
    localparam logic [LIVE_W-1:0] LIVE_INIT  = live_of(CTRL_INIT);
    localparam mst_mode_e         MODE_INIT  = CTRL_INIT[C_LOOP] ? LIVE_LOOP : LIVE_FIXED;

    logic [7:0]        ctrl_q;
    logic [7:0]        stat_q;
    logic              ctrl_wr;
    logic              stat_clr;
    logic [7:0]        ctrl_new;
    logic [LIVE_W-1:0] loop_live, fixed_live, live_new, evt;
    logic              next_is_loop;
    mst_mode_e         mode_q;

    assign ctrl_wr  = bus_wr & ~bus_sel;
    assign stat_clr = bus_rd & ~bus_wr & bus_sel;
    assign ctrl_new = bus_wdata & CTRL_KEEP;

    mst_live_map u_map (
        .ctrl       (ctrl_new),
        .loop_live  (loop_live),
        .fixed_live (fixed_live)
    );

    mst_mode_fsm #(.RESET_MODE(MODE_INIT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .loop_req     (ctrl_new[C_LOOP]),
        .mode_q       (mode_q),
        .next_is_loop (next_is_loop)
    );

    assign live_new = next_is_loop ? loop_live : fixed_live;

    mst_delta_gen u_delta (
        .old_live (stat_q[7:4]),
        .new_live (live_new),
        .evt      (evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= {LIVE_INIT, 4'b0000};
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_new;
            stat_q <= {live_new, stat_q[3:0] | evt};
        end else if (stat_clr) begin
            stat_q[3:0] <= 4'b0000;
        end
    end

    assign rdata     = bus_sel ? stat_q : ctrl_q;
    assign ctrl_out  = ctrl_q;
    assign delta_any = |stat_q[3:0];
endmodule

module mst_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       bus_sel,
    input logic [7:0] bus_wdata,
    input logic [7:0] ctrl_q,
    input logic [7:0] stat_q
);
    p_ctrl_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7:5] == 3'b000);

    p_loop_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[4] |-> (stat_q[7:4] == {ctrl_q[3], ctrl_q[2], ctrl_q[0], ctrl_q[1]}));

    p_fixed_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[4] |-> (stat_q[7:4] == 4'b1010));

    p_no_rising_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && !stat_q[6] && !stat_q[2]) |=> !stat_q[2]);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && !bus_wr && bus_sel) |=>
            ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_sel) |=> (stat_q[3:0] == 4'b0000));

    p_stat_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel) |=> ($stable(stat_q) && $stable(ctrl_q)));

    p_wr_beats_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd && !bus_sel && stat_q[0]) |=> stat_q[0]);
endmodule

bind modem_status_gen mst_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q)
);

// File: tb/modem_status_gen_tb_top.sv
module modem_status_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] rdata, ctrl_out;
    logic       delta_any;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [7:0] m_ctrl = 8'h00;
    logic [7:0] m_stat = 8'hA0;

    always #4 clk = ~clk;

    modem_status_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .rdata(rdata),
        .ctrl_out(ctrl_out), .delta_any(delta_any)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            failures++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [3:0] ref_live(input logic [7:0] c);
        logic [3:0] v;
        if (c[4]) v = {c[3], c[2], c[0], c[1]};
        else      v = 4'b1010;
        return v;
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // compare every port against the model; inputs already applied for this cycle
    task automatic compare(input string tag);
        check8({tag, " rdata"}, rdata, bus_sel ? m_stat : m_ctrl);
        check8("R3 ctrl_out", ctrl_out, m_ctrl);
        check8("R10 delta_any", {7'd0, delta_any}, {7'd0, |m_stat[3:0]});
    endtask

    task automatic model_edge(input logic wr, input logic rd, input logic sel, input logic [7:0] d);
        logic [7:0] nc;
        logic [3:0] nl, ol, dl;
        if (wr) begin
            if (!sel) begin
                nc = d & 8'h1F;
                nl = ref_live(nc);
                ol = m_stat[7:4];
                dl = m_stat[3:0];
                if (nl[0] != ol[0]) dl[0] = 1'b1;
                if (nl[1] != ol[1]) dl[1] = 1'b1;
                if (nl[3] != ol[3]) dl[3] = 1'b1;
                if (ol[2] && !nl[2]) dl[2] = 1'b1;
                m_stat = {nl, dl};
                m_ctrl = nc;
            end
        end else if (rd && sel) begin
            m_stat[3:0] = 4'b0000;
        end
    endtask

    task automatic step(input logic wr, input logic rd, input logic sel,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = d;
        #1;
        compare(tag);
        @(posedge clk);
        model_edge(wr, rd, sel, d);
    endtask

    task automatic peek_stat(input string tag, input logic [7:0] exp);
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; bus_sel = 1; bus_wdata = 8'h00;
        #1;
        check8(tag, rdata, exp);
        compare(tag);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        peek_stat("R9 reset status", 8'hA0);
        step(0, 1, 0, 8'h00, "R9 ctrl reset, R7 ctrl read no effect");
        peek_stat("R7 status after ctrl read", 8'hA0);

        // R3 mask, R1 loopback, R4 CTS change
        step(1, 0, 0, 8'hFF, "R3 ctrl write");
        peek_stat("R1 R4 loop all high", 8'hF1);
        step(0, 1, 1, 8'h00, "R7 status read returns");
        peek_stat("R7 flags cleared", 8'hF0);

        // R5 trailing edge on RI
        step(1, 0, 0, 8'h1B, "R5 OUT1 low");
        peek_stat("R5 ring falling sets bit2", 8'hB4);
        step(0, 1, 1, 8'h00, "R7 read");
        step(1, 0, 0, 8'h1F, "R5 OUT1 high");
        peek_stat("R5 ring rising no flag", 8'hF0);

        // R8 status write ignored
        step(1, 0, 1, 8'h0F, "R8 status write");
        peek_stat("R8 status unchanged", 8'hF0);

        // R4 all deltas, R10
        step(1, 0, 0, 8'h10, "R4 loop all low");
        peek_stat("R4 all flags", 8'h0F);
        // R6 sticky and R2 fixed mapping
        step(1, 0, 0, 8'h00, "R2 leave loop");
        peek_stat("R2 R6 fixed map keeps flags", 8'hAF);
        // R11 write beats read
        step(1, 1, 0, 8'h00, "R11 write plus read");
        peek_stat("R11 flags kept", 8'hAF);
        step(1, 1, 1, 8'h55, "R11 status write plus read");
        peek_stat("R11 R8 still kept", 8'hAF);
        step(0, 1, 1, 8'h00, "R7 read");
        peek_stat("R7 R10 cleared", 8'hA0);

        // random mix compared every clock
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], r[2], r[15:8], "R1 R2 R4 R6 random");
        end
        peek_stat("R6 final", m_stat);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule